// File: doc/BRIEF.md
# Sectioned Register File Address Sequencer

This block produces byte addresses for a small register file of clock and control registers. The register file is split into five fixed sections. In address order they are: alarm set A (8 bytes, 0..7), alarm set B (8 bytes, 8..15), control (2 bytes, 16..17), time (8 bytes, 18..25) and status (1 byte, 26). Addresses 27 to 63 of the 6-bit space belong to no section. A transaction starts in one of two ways. An explicit start loads an address from the bus. A resume start continues from the address retained after the previous transaction.

Each byte-advance strobe moves the address forward. When the last byte of a section is reached, the address wraps to the first byte of that same section, so one transaction never leaves the section it started in. For each byte the block reports whether a write to the current address is permitted. Status writes are always allowed. Every other section needs both write-enable latches set. The status section takes one byte per transaction: a second byte ends the transaction and raises a one-cycle end indication. The storage and the serial protocol sit outside this block.

Top module: `regseq_top`

## Requirements
- R1: After reset, curAddr is 0, busy is 0, writePermit is 0 and overrunEnd is 0.
- R2: A startValid pulse sets busy and loads curAddr from startAddr, both visible the cycle after the edge. The transaction is a write when isWrite is 1 at that edge.
- R3: While busy, an advance strobe inside a section adds one to curAddr on the next cycle when the address is not the section's last byte.
- R4: An advance on the last byte of a section (7, 15, 17, 25 or 26) sets curAddr to that section's first byte (0, 8, 16, 18 or 26).
- R5: secSel gives the section of curAddr: 0 for 0..7, 1 for 8..15, 2 for 16..17, 3 for 18..25, 4 for 26. addrValid is 1 exactly for addresses 0..26. For addresses 27..63, writePermit is 0 and an advance leaves curAddr unchanged.
- R6: In sections 0 to 3, writePermit is 1 only when busy, the transaction is a write, and both wel and rwel are 1.
- R7: In the status section (secSel 4), writePermit is 1 for the first byte of a write transaction whatever wel and rwel are.
- R8: A second advance in the status section clears busy, pulses overrunEnd high for exactly one cycle and leaves curAddr unchanged.
- R9: stopIn clears busy and keeps curAddr. A startCurrent pulse sets busy again and continues from the retained curAddr. startValid takes precedence over startCurrent, and both take precedence over stopIn.
- R10: During a read transaction (isWrite 0 at the start), writePermit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start a transaction at startAddr |
| startCurrent | input | 1 | Start a transaction at the retained address |
| startAddr | input | 6 | Start address for startValid |
| isWrite | input | 1 | Transaction direction, sampled at start (1 = write) |
| advance | input | 1 | Current byte accessed; move to the next byte |
| stopIn | input | 1 | End the transaction |
| wel | input | 1 | First write-enable latch |
| rwel | input | 1 | Second write-enable latch |
| curAddr | output | 6 | Current register address |
| addrValid | output | 1 | curAddr lies inside a section |
| secSel | output | 3 | Section index of curAddr |
| busy | output | 1 | A transaction is open |
| writePermit | output | 1 | A write to curAddr is allowed now |
| overrunEnd | output | 1 | One-cycle pulse: the status section was over-read |

## Verification
The bench targets every section boundary. A design that wrapped at the end of the address space, or at a neighbouring section's base, would leave the section instead of returning to its first byte; the one-byte status section, which must wrap onto itself, is the sharpest case. It also drives status writes with both latches clear, and latch-protected writes with only one latch set. A design that gated status writes with the latches would refuse the first case, and one that ignored a latch would grant the second. Random streams of starts, resumes, stops and advances, including starts above 26, expose a retained address that is off by one after a stop, an address that wanders beyond 26, and an overrun pulse that lasts longer than one cycle.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  localparam int ADDR_W = 6;
  localparam int NUM_SEC = 5;
  localparam int SEC_W = $clog2(NUM_SEC);
  localparam int STATUS_SEC = 4;
  localparam int SEC_SIZE [NUM_SEC] = '{8, 8, 2, 8, 1};

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [SEC_W-1:0] sec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;

  function automatic int secBase(input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < NUM_SEC; k++) begin
      if (k < idx) acc += SEC_SIZE[k];
    end
    return acc;
  endfunction
endpackage

// File: rtl/regseq_path.sv
module regseq_path
  import regseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  addr_t      startAddr,
  output addr_t      curAddr,
  output logic       addrValid,
  output sec_t       secSel,
  output logic       secIsStatus
);
  addr_t addrQ;
  addr_t nextAddr;
  logic [NUM_SEC-1:0] hit;
  addr_t wrapNext [NUM_SEC];

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    localparam int BASE = secBase(g);
    localparam int LAST = BASE + SEC_SIZE[g] - 1;
    addr_t offset;
    assign offset = addrQ - ADDR_W'(BASE);
    assign hit[g] = offset < ADDR_W'(SEC_SIZE[g]);
    assign wrapNext[g] = (addrQ == ADDR_W'(LAST)) ? ADDR_W'(BASE) : addrQ + 1'b1;
  end

  always_comb begin
    nextAddr = addrQ;
    secSel = '0;
    for (int k = 0; k < NUM_SEC; k++) begin
      if (hit[k]) begin
        secSel = sec_t'(k);
        nextAddr = wrapNext[k];
      end
    end
  end

  assign addrValid = |hit;
  assign secIsStatus = hit[STATUS_SEC];
  assign curAddr = addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) addrQ <= '0;
    else if (strobe.load) addrQ <= startAddr;
    else if (strobe.step) addrQ <= nextAddr;
  end
endmodule

// File: rtl/regseq_ctrl.sv
module regseq_ctrl
  import regseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       startCurrent,
  input  logic       isWrite,
  input  logic       advance,
  input  logic       stopIn,
  input  logic       wel,
  input  logic       rwel,
  input  logic       addrValid,
  input  logic       secIsStatus,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       writePermit,
  output logic       overrunEnd
);
  logic activeQ, wrModeQ, statusUsedQ, endPulseQ;
  logic anyStart, overrun;

  assign anyStart = startValid | startCurrent;
  assign overrun = activeQ & advance & secIsStatus & statusUsedQ;

  assign strobe.load = startValid;
  assign strobe.step = activeQ & advance & ~anyStart & ~stopIn & ~overrun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      wrModeQ <= 1'b0;
      statusUsedQ <= 1'b0;
      endPulseQ <= 1'b0;
    end else if (anyStart) begin
      activeQ <= 1'b1;
      wrModeQ <= isWrite;
      statusUsedQ <= 1'b0;
      endPulseQ <= 1'b0;
    end else begin
      endPulseQ <= 1'b0;
      if (stopIn) begin
        activeQ <= 1'b0;
      end else if (overrun) begin
        activeQ <= 1'b0;
        endPulseQ <= 1'b1;
      end else if (activeQ && advance && secIsStatus) begin
        statusUsedQ <= 1'b1;
      end
    end
  end

  assign busy = activeQ;
  assign overrunEnd = endPulseQ;
  assign writePermit = activeQ & wrModeQ & addrValid &
                       (secIsStatus ? ~statusUsedQ : (wel & rwel));
endmodule

// File: rtl/regseq_top.sv
module regseq_top
  import regseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              startCurrent,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              isWrite,
  input  logic              advance,
  input  logic              stopIn,
  input  logic              wel,
  input  logic              rwel,
  output logic [ADDR_W-1:0] curAddr,
  output logic              addrValid,
  output logic [SEC_W-1:0]  secSel,
  output logic              busy,
  output logic              writePermit,
  output logic              overrunEnd
);
  seqStrobe_t strobe;
  logic secIsStatus;

  regseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startCurrent(startCurrent),
    .isWrite(isWrite), .advance(advance), .stopIn(stopIn), .wel(wel), .rwel(rwel),
    .addrValid(addrValid), .secIsStatus(secIsStatus), .strobe(strobe),
    .busy(busy), .writePermit(writePermit), .overrunEnd(overrunEnd)
  );

  regseq_path u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .curAddr(curAddr), .addrValid(addrValid), .secSel(secSel), .secIsStatus(secIsStatus)
  );
endmodule

// File: rtl/regseq_checker.sv
module regseq_checker
  import regseq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic              startCurrent,
  input logic              advance,
  input logic              stopIn,
  input logic              wel,
  input logic              rwel,
  input logic [ADDR_W-1:0] curAddr,
  input logic              addrValid,
  input logic [SEC_W-1:0]  secSel,
  input logic              busy,
  input logic              writePermit,
  input logic              overrunEnd
);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    overrunEnd |=> !overrunEnd);

  a_r8_idle_on_end: assert property (@(posedge clk) disable iff (!rstN)
    overrunEnd |-> !busy);

  a_r5_invalid_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |-> !writePermit);

  a_r6_latches_needed: assert property (@(posedge clk) disable iff (!rstN)
    (writePermit && secSel != SEC_W'(STATUS_SEC)) |-> (wel && rwel));

  a_r5_invalid_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !addrValid && advance && !startValid && !startCurrent && !stopIn)
      |=> $stable(curAddr));

  a_r9_stop_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (stopIn && !startValid && !startCurrent) |=> (!busy && $stable(curAddr)));

  a_r4_same_section: assert property (@(posedge clk) disable iff (!rstN)
    (busy && advance && addrValid && !startValid && !startCurrent && !stopIn)
      |=> (secSel == $past(secSel)));
endmodule

bind regseq_top regseq_checker u_chk (.*);

// File: tb/sim_regseq_top.sv
`timescale 1ns/1ps
module sim_regseq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 0, startCurrent = 0, isWrite = 0, advance = 0, stopIn = 0;
  logic wel = 0, rwel = 0;
  logic [5:0] startAddr = '0;
  logic [5:0] curAddr;
  logic addrValid, busy, writePermit, overrunEnd;
  logic [2:0] secSel;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [5:0] mAddr;
  bit mActive, mWr, mUsed, mEnd;

  always #4 clk = ~clk;

  regseq_top u0 (.*);

  function automatic int mSec(input logic [5:0] a);
    if (a < 8) return 0;
    if (a < 16) return 1;
    if (a < 18) return 2;
    if (a < 26) return 3;
    if (a == 26) return 4;
    return 7;
  endfunction

  function automatic int mBase(input int s);
    case (s) 0: return 0; 1: return 8; 2: return 16; 3: return 18; default: return 26; endcase
  endfunction

  function automatic int mLast(input int s);
    case (s) 0: return 7; 1: return 15; 2: return 17; 3: return 25; default: return 26; endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int s;
    bit ewp;
    s = mSec(mAddr);
    ewp = mActive && mWr && s != 7 && ((s == 4) ? !mUsed : (wel && rwel));
    chk(curAddr == mAddr, "R3 curAddr", curAddr, mAddr);
    chk(busy == mActive, "R2 busy", busy, mActive);
    chk(addrValid == (s != 7), "R5 addrValid", addrValid, s != 7);
    if (s != 7) chk(secSel == 3'(s), "R5 secSel", secSel, s);
    if (!mWr && mActive) chk(writePermit == 0, "R10 read permit", writePermit, 0);
    else if (s == 4) chk(writePermit == ewp, "R7 status permit", writePermit, ewp);
    else chk(writePermit == ewp, "R6 permit", writePermit, ewp);
    chk(overrunEnd == mEnd, "R8 overrunEnd", overrunEnd, mEnd);
  endtask

  task automatic modelUpdate();
    int s;
    if (startValid || startCurrent) begin
      if (startValid) mAddr = startAddr;
      mActive = 1; mWr = isWrite; mUsed = 0; mEnd = 0;
    end else begin
      mEnd = 0;
      if (stopIn) mActive = 0;
      else if (mActive && advance) begin
        s = mSec(mAddr);
        if (s == 4 && mUsed) begin
          mActive = 0; mEnd = 1;
        end else begin
          if (s == 4) mUsed = 1;
          if (s != 7) mAddr = (int'(mAddr) == mLast(s)) ? 6'(mBase(s)) : mAddr + 6'd1;
        end
      end
    end
  endtask

  task automatic doCycle(input bit sv, input bit sc, input int sa, input bit wr,
                         input bit adv, input bit stp, input bit w, input bit rw);
    startValid = sv; startCurrent = sc; startAddr = 6'(sa); isWrite = wr;
    advance = adv; stopIn = stp; wel = w; rwel = rw;
    @(negedge clk);
    compareAll();
    @(posedge clk);
    modelUpdate();
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mAddr = 0; mActive = 0; mWr = 0; mUsed = 0; mEnd = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(curAddr == 0 && !busy && !writePermit && !overrunEnd, "R1 reset", curAddr, 0);
    rstN = 1;

    // R4: wrap within time section 25 -> 18
    doCycle(1, 0, 25, 1, 0, 0, 1, 1);
    doCycle(0, 0, 0, 0, 1, 0, 1, 1);
    #1 chk(curAddr == 18, "R4 wrap time", curAddr, 18);
    // R4: control 17 -> 16
    doCycle(1, 0, 17, 0, 0, 0, 0, 0);
    doCycle(0, 0, 0, 0, 1, 0, 0, 0);
    #1 chk(curAddr == 16, "R4 wrap control", curAddr, 16);
    // R6: one latch only
    doCycle(1, 0, 3, 1, 0, 0, 1, 0);
    wel = 1; rwel = 0; #1;
    chk(writePermit == 0, "R6 single latch", writePermit, 0);
    // R7: status write with no latches, then overrun R8
    doCycle(1, 0, 26, 1, 0, 0, 0, 0);
    wel = 0; rwel = 0; #1;
    chk(writePermit == 1, "R7 status write", writePermit, 1);
    doCycle(0, 0, 0, 0, 1, 0, 0, 0);
    doCycle(0, 0, 0, 0, 1, 0, 0, 0);
    #1 chk(overrunEnd == 1 && busy == 0 && curAddr == 26, "R8 overrun", overrunEnd, 1);
    // R9: stop then resume at retained address
    doCycle(1, 0, 9, 0, 0, 0, 0, 0);
    doCycle(0, 0, 0, 0, 1, 0, 0, 0);
    doCycle(0, 0, 0, 0, 0, 1, 0, 0);
    doCycle(0, 1, 0, 0, 0, 0, 0, 0);
    #1 chk(busy == 1 && curAddr == 10, "R9 resume", curAddr, 10);
    // R5: invalid address holds
    doCycle(1, 0, 40, 1, 0, 0, 1, 1);
    doCycle(0, 0, 0, 0, 1, 0, 1, 1);
    #1 chk(curAddr == 40 && addrValid == 0, "R5 invalid hold", curAddr, 40);
    // R10: read never permits
    doCycle(1, 0, 20, 0, 0, 0, 1, 1);
    wel = 1; rwel = 1; #1;
    chk(writePermit == 0, "R10 read", writePermit, 0);

    for (int i = 0; i < 4000; i++) begin
      int r;
      bit sv, sc, stp, adv;
      r = $urandom_range(0, 99);
      sv = (r < 8);
      sc = (r >= 8 && r < 11);
      stp = (r >= 11 && r < 16);
      adv = ($urandom_range(0, 3) != 0);
      doCycle(sv, sc, $urandom_range(0, 34), $urandom_range(0, 1) == 1, adv, stp,
              $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0);
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule